// File: doc/BRIEF.md
# Double-Buffered PHY Configuration Register

This block keeps two copies of a 16-bit line-coder configuration. The host fills a pending copy through a byte-wide register bus, one byte per write. A second, live copy drives the line coder. The live copy changes only when the host commits the pending copy. It does that by driving the top bit of the enable register from one to zero. Because of this, the coder never sees a half-written word.

The live word is split into three outputs:

- a 6-bit baud divisor from bits 15:10;
- a 5-bit preamble length from bits 4:0;
- a 4-bit pulse width built from bit 10 (its upper bit) and bits 7:5 (its lower three bits).

Bit 10 therefore feeds both the baud divisor and the pulse width.

The enable register also carries the host's per-mode switches (fast, medium, slow), transmit and receive enables and a 16-bit CRC select. It holds a configuration-error flag as well, which the hardware sets when a commit asks for more than one speed mode at once. A rejected commit leaves the live word as it was.

Top module: `phy_cfg_dbuf`

## Requirements
- R1: After synchronous reset, the pending word, the live word and every enable bit read as zero, and all decoded outputs are zero.
- R2: A write to offset 0x18 (low byte) or 0x19 (high byte) updates the pending word, which reads back at the same offsets. It leaves the live word and the decoded outputs unchanged.
- R3: A write to the enable register (offset 0x15) that has bit 7 = 0, while the stored bit 7 is 1, is a commit. If the written bits 5:3 hold at most one 1, the live word takes the pending word. The new live word is readable at 0x16 (low) and 0x17 (high) in the next cycle.
- R4: A write to 0x15 that keeps bit 7 low, or that raises it, does not change the live word.
- R5: The outputs decode the live word as follows: baudDiv = bits 15:10, preambleLen = bits 4:0, pulseWidth = {bit 10, bits 7:5}.
- R6: A commit whose written bits 5:3 hold two or more 1s sets the error flag (bit 6 at 0x15, and cfgError) and keeps the previous live word.
- R7: A successful commit clears the error flag. Any other write to 0x15 keeps the flag at its old value, and host writes to bit 6 are ignored.
- R8: Bits 5, 4, 3, 2, 1 and 0 of 0x15 are stored as written. They drive fastOn, midOn, slowOn, txEnable, rxEnable and crc16Sel, and change only on writes to 0x15.
- R9: Writes to 0x16 and 0x17 are ignored. Reads of any unmapped offset return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wrEn | input | 1 | Write strobe for the byte at regAddr |
| regAddr | input | 5 | Register offset for write and read |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data for regAddr, combinational |
| baudDiv | output | 6 | Baud divisor field of the live word |
| pulseWidth | output | 4 | Pulse-width field of the live word |
| preambleLen | output | 5 | Preamble length field of the live word |
| fastOn | output | 1 | Fast mode switched on |
| midOn | output | 1 | Medium mode switched on |
| slowOn | output | 1 | Slow mode switched on |
| txEnable | output | 1 | Transmit enable |
| rxEnable | output | 1 | Receive enable |
| crc16Sel | output | 1 | 16-bit CRC selected |
| cfgError | output | 1 | Last commit was rejected |

## Verification
Every write takes effect at the clock edge that samples it. Register contents, the decoded fields, the mode outputs and the error flag are therefore due one cycle after the write strobe. rdData is a combinational view of those registers.

The bench drives each write at a falling edge and drops the strobe at the next falling edge. At that same point it moves regAddr to the offset to read back, and it samples a moment later. The rising edge in between is the only one that could have changed the result. The checker's clocked properties look one cycle ahead of each qualifying write, which matches the same single-register latency.

// File: rtl/phy_cfg_pkg.sv
package phy_cfg_pkg;

  // Bit positions inside the enable register; the commit bit and the
  // mode bits are decoded by the control path, so these are fixed.
  localparam int EN_COMMIT_BIT = 7;
  localparam int EN_ERR_BIT    = 6;
  localparam int EN_FAST_BIT   = 5;
  localparam int EN_MID_BIT    = 4;
  localparam int EN_SLOW_BIT   = 3;
  localparam int EN_TX_BIT     = 2;
  localparam int EN_RX_BIT     = 1;
  localparam int EN_CRC_BIT    = 0;

  // Strobes handed from the control path to the datapath, one cycle.
  typedef struct packed {
    logic loadNewLo;
    logic loadNewHi;
    logic loadEnable;
    logic commit;
    logic reject;
  } cfgStrobes_t;

endpackage

// File: rtl/phy_cfg_ctrl.sv
module phy_cfg_ctrl
  import phy_cfg_pkg::*;
#(
  parameter int ADDR_W     = 5,
  parameter int MODE_W     = 3,
  parameter logic [ADDR_W-1:0] OFF_EN     = 5'h15,
  parameter logic [ADDR_W-1:0] OFF_NEW_LO = 5'h18,
  parameter logic [ADDR_W-1:0] OFF_NEW_HI = 5'h19
) (
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              commitBitWr,
  input  logic [MODE_W-1:0] modeBitsWr,
  input  logic              commitBitNow,
  output cfgStrobes_t       strobes
);

  localparam int CNT_W = $clog2(MODE_W + 1);

  logic             hitEnable;
  logic             fallEdge;
  logic [CNT_W-1:0] modeCount;
  logic             multiMode;

  assign hitEnable = wrEn && (regAddr == OFF_EN);
  // Commit only on a 1-to-0 move of the stored control bit.
  assign fallEdge  = hitEnable && commitBitNow && !commitBitWr;

  always_comb begin
    modeCount = '0;
    for (int i = 0; i < MODE_W; i++) begin
      modeCount = modeCount + CNT_W'(modeBitsWr[i]);
    end
  end

  assign multiMode = modeCount > CNT_W'(1);

  always_comb begin
    strobes            = '0;
    strobes.loadNewLo  = wrEn && (regAddr == OFF_NEW_LO);
    strobes.loadNewHi  = wrEn && (regAddr == OFF_NEW_HI);
    strobes.loadEnable = hitEnable;
    strobes.commit     = fallEdge && !multiMode;
    strobes.reject     = fallEdge && multiMode;
  end

endmodule

// File: rtl/phy_cfg_datapath.sv
module phy_cfg_datapath
  import phy_cfg_pkg::*;
#(
  parameter int ADDR_W       = 5,
  parameter int DATA_W       = 8,
  parameter int BAUD_LSB     = 10,
  parameter int PRE_W        = 5,
  parameter int WIDTH_HI_BIT = 10,
  parameter int WIDTH_LO_LSB = 5,
  parameter int WIDTH_LO_W   = 3,
  parameter logic [ADDR_W-1:0] OFF_EN     = 5'h15,
  parameter logic [ADDR_W-1:0] OFF_CUR_LO = 5'h16,
  parameter logic [ADDR_W-1:0] OFF_CUR_HI = 5'h17,
  parameter logic [ADDR_W-1:0] OFF_NEW_LO = 5'h18,
  parameter logic [ADDR_W-1:0] OFF_NEW_HI = 5'h19
) (
  input  logic                        clk,
  input  logic                        rst,
  input  cfgStrobes_t                 strobes,
  input  logic [DATA_W-1:0]           wrData,
  input  logic [ADDR_W-1:0]           regAddr,
  output logic [DATA_W-1:0]           rdData,
  output logic                        commitBitNow,
  output logic [2*DATA_W-BAUD_LSB-1:0] baudDiv,
  output logic [WIDTH_LO_W:0]         pulseWidth,
  output logic [PRE_W-1:0]            preambleLen,
  output logic [DATA_W-1:0]           enableReg
);

  localparam int CFG_W   = 2 * DATA_W;
  localparam int LANES   = CFG_W / DATA_W;

  logic [CFG_W-1:0]  newCfg;
  logic [CFG_W-1:0]  curCfg;
  logic [DATA_W-1:0] enReg;
  logic [DATA_W-1:0] enNext;
  logic              errNext;
  logic [LANES-1:0]  laneLoad;

  assign laneLoad = {strobes.loadNewHi, strobes.loadNewLo};

  // Pending word, one register per byte lane.
  for (genvar b = 0; b < LANES; b++) begin : g_newLane
    always_ff @(posedge clk) begin
      if (rst) begin
        newCfg[b*DATA_W +: DATA_W] <= '0;
      end else if (laneLoad[b]) begin
        newCfg[b*DATA_W +: DATA_W] <= wrData;
      end
    end
  end

  // Live word, loaded as a whole on an accepted commit.
  always_ff @(posedge clk) begin
    if (rst) begin
      curCfg <= '0;
    end else if (strobes.commit) begin
      curCfg <= newCfg;
    end
  end

  always_comb begin
    if (strobes.commit) begin
      errNext = 1'b0;
    end else if (strobes.reject) begin
      errNext = 1'b1;
    end else begin
      errNext = enReg[EN_ERR_BIT];
    end
    enNext             = wrData;
    enNext[EN_ERR_BIT] = errNext;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      enReg <= '0;
    end else if (strobes.loadEnable) begin
      enReg <= enNext;
    end
  end

  // Readback: live word is view-only, unmapped offsets return zero.
  always_comb begin
    if (regAddr == OFF_EN) begin
      rdData = enReg;
    end else if (regAddr == OFF_CUR_LO) begin
      rdData = curCfg[0 +: DATA_W];
    end else if (regAddr == OFF_CUR_HI) begin
      rdData = curCfg[DATA_W +: DATA_W];
    end else if (regAddr == OFF_NEW_LO) begin
      rdData = newCfg[0 +: DATA_W];
    end else if (regAddr == OFF_NEW_HI) begin
      rdData = newCfg[DATA_W +: DATA_W];
    end else begin
      rdData = '0;
    end
  end

  assign commitBitNow = enReg[EN_COMMIT_BIT];
  assign enableReg    = enReg;
  assign baudDiv      = curCfg[CFG_W-1:BAUD_LSB];
  assign preambleLen  = curCfg[PRE_W-1:0];
  assign pulseWidth   = {curCfg[WIDTH_HI_BIT], curCfg[WIDTH_LO_LSB +: WIDTH_LO_W]};

endmodule

// File: rtl/phy_cfg_dbuf.sv
module phy_cfg_dbuf
  import phy_cfg_pkg::*;
#(
  parameter int ADDR_W       = 5,
  parameter int DATA_W       = 8,
  parameter int BAUD_LSB     = 10,
  parameter int PRE_W        = 5,
  parameter int WIDTH_HI_BIT = 10,
  parameter int WIDTH_LO_LSB = 5,
  parameter int WIDTH_LO_W   = 3,
  parameter logic [ADDR_W-1:0] OFF_EN     = 5'h15,
  parameter logic [ADDR_W-1:0] OFF_CUR_LO = 5'h16,
  parameter logic [ADDR_W-1:0] OFF_CUR_HI = 5'h17,
  parameter logic [ADDR_W-1:0] OFF_NEW_LO = 5'h18,
  parameter logic [ADDR_W-1:0] OFF_NEW_HI = 5'h19
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         wrEn,
  input  logic [ADDR_W-1:0]            regAddr,
  input  logic [DATA_W-1:0]            wrData,
  output logic [DATA_W-1:0]            rdData,
  output logic [2*DATA_W-BAUD_LSB-1:0] baudDiv,
  output logic [WIDTH_LO_W:0]          pulseWidth,
  output logic [PRE_W-1:0]             preambleLen,
  output logic                         fastOn,
  output logic                         midOn,
  output logic                         slowOn,
  output logic                         txEnable,
  output logic                         rxEnable,
  output logic                         crc16Sel,
  output logic                         cfgError
);

  localparam int MODE_W = EN_FAST_BIT - EN_SLOW_BIT + 1;

  cfgStrobes_t       strobes;
  logic              commitBitNow;
  logic [DATA_W-1:0] enableReg;

  phy_cfg_ctrl #(
    .ADDR_W     (ADDR_W),
    .MODE_W     (MODE_W),
    .OFF_EN     (OFF_EN),
    .OFF_NEW_LO (OFF_NEW_LO),
    .OFF_NEW_HI (OFF_NEW_HI)
  ) ctrl_i (
    .wrEn         (wrEn),
    .regAddr      (regAddr),
    .commitBitWr  (wrData[EN_COMMIT_BIT]),
    .modeBitsWr   (wrData[EN_FAST_BIT:EN_SLOW_BIT]),
    .commitBitNow (commitBitNow),
    .strobes      (strobes)
  );

  phy_cfg_datapath #(
    .ADDR_W       (ADDR_W),
    .DATA_W       (DATA_W),
    .BAUD_LSB     (BAUD_LSB),
    .PRE_W        (PRE_W),
    .WIDTH_HI_BIT (WIDTH_HI_BIT),
    .WIDTH_LO_LSB (WIDTH_LO_LSB),
    .WIDTH_LO_W   (WIDTH_LO_W),
    .OFF_EN       (OFF_EN),
    .OFF_CUR_LO   (OFF_CUR_LO),
    .OFF_CUR_HI   (OFF_CUR_HI),
    .OFF_NEW_LO   (OFF_NEW_LO),
    .OFF_NEW_HI   (OFF_NEW_HI)
  ) dp_i (
    .clk          (clk),
    .rst          (rst),
    .strobes      (strobes),
    .wrData       (wrData),
    .regAddr      (regAddr),
    .rdData       (rdData),
    .commitBitNow (commitBitNow),
    .baudDiv      (baudDiv),
    .pulseWidth   (pulseWidth),
    .preambleLen  (preambleLen),
    .enableReg    (enableReg)
  );

  assign fastOn   = enableReg[EN_FAST_BIT];
  assign midOn    = enableReg[EN_MID_BIT];
  assign slowOn   = enableReg[EN_SLOW_BIT];
  assign txEnable = enableReg[EN_TX_BIT];
  assign rxEnable = enableReg[EN_RX_BIT];
  assign crc16Sel = enableReg[EN_CRC_BIT];
  assign cfgError = enableReg[EN_ERR_BIT];

endmodule

// File: rtl/phy_cfg_dbuf_chk.sv
module phy_cfg_dbuf_chk #(
  parameter int ADDR_W   = 5,
  parameter int BAUD_W   = 6,
  parameter int PW_W     = 4,
  parameter int PRE_W    = 5,
  parameter logic [ADDR_W-1:0] OFF_EN     = 5'h15,
  parameter logic [ADDR_W-1:0] OFF_CUR_LO = 5'h16,
  parameter logic [ADDR_W-1:0] OFF_CUR_HI = 5'h17,
  parameter logic [ADDR_W-1:0] OFF_NEW_LO = 5'h18,
  parameter logic [ADDR_W-1:0] OFF_NEW_HI = 5'h19
) (
  input logic              clk,
  input logic              rst,
  input logic              wrEn,
  input logic [ADDR_W-1:0] regAddr,
  input logic              wrTop,
  input logic [2:0]        wrModes,
  input logic [BAUD_W-1:0] baudDiv,
  input logic [PW_W-1:0]   pulseWidth,
  input logic [PRE_W-1:0]  preambleLen,
  input logic              fastOn,
  input logic              midOn,
  input logic              slowOn,
  input logic              txEnable,
  input logic              rxEnable,
  input logic              crc16Sel,
  input logic              cfgError
);

  logic topSeen;
  logic enWrite;
  logic attempt;
  logic multi;

  always_ff @(posedge clk) begin
    if (rst) begin
      topSeen <= 1'b0;
    end else if (wrEn && regAddr == OFF_EN) begin
      topSeen <= wrTop;
    end
  end

  assign enWrite = wrEn && (regAddr == OFF_EN);
  assign attempt = enWrite && topSeen && !wrTop;
  assign multi   = $countones(wrModes) > 1;

  // R2
  new_write_no_effect_chk: assert property (@(posedge clk) disable iff (rst)
    wrEn && (regAddr == OFF_NEW_LO || regAddr == OFF_NEW_HI)
    |=> $stable(baudDiv) && $stable(pulseWidth) && $stable(preambleLen));

  // R4
  no_commit_chk: assert property (@(posedge clk) disable iff (rst)
    enWrite && !attempt
    |=> $stable(baudDiv) && $stable(pulseWidth) && $stable(preambleLen));

  // R6
  reject_chk: assert property (@(posedge clk) disable iff (rst)
    attempt && multi
    |=> cfgError && $stable(baudDiv) && $stable(pulseWidth) && $stable(preambleLen));

  // R7
  commit_clear_chk: assert property (@(posedge clk) disable iff (rst)
    attempt && !multi |=> !cfgError);

  // R7
  err_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !attempt |=> $stable(cfgError));

  // R8
  mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !enWrite |=> $stable({fastOn, midOn, slowOn, txEnable, rxEnable, crc16Sel}));

  // R9
  cur_write_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    wrEn && (regAddr == OFF_CUR_LO || regAddr == OFF_CUR_HI)
    |=> $stable(baudDiv) && $stable(pulseWidth) && $stable(preambleLen));

endmodule

bind phy_cfg_dbuf phy_cfg_dbuf_chk #(
  .ADDR_W     (ADDR_W),
  .BAUD_W     (2*DATA_W-BAUD_LSB),
  .PW_W       (WIDTH_LO_W+1),
  .PRE_W      (PRE_W),
  .OFF_EN     (OFF_EN),
  .OFF_CUR_LO (OFF_CUR_LO),
  .OFF_CUR_HI (OFF_CUR_HI),
  .OFF_NEW_LO (OFF_NEW_LO),
  .OFF_NEW_HI (OFF_NEW_HI)
) chk_i (
  .clk         (clk),
  .rst         (rst),
  .wrEn        (wrEn),
  .regAddr     (regAddr),
  .wrTop       (wrData[7]),
  .wrModes     (wrData[5:3]),
  .baudDiv     (baudDiv),
  .pulseWidth  (pulseWidth),
  .preambleLen (preambleLen),
  .fastOn      (fastOn),
  .midOn       (midOn),
  .slowOn      (slowOn),
  .txEnable    (txEnable),
  .rxEnable    (rxEnable),
  .crc16Sel    (crc16Sel),
  .cfgError    (cfgError)
);

// File: tb/phy_cfg_dbuf_tb_top.sv
module phy_cfg_dbuf_tb_top;

  logic       clk = 1'b0;
  logic       rst;
  logic       wrEn;
  logic [4:0] regAddr;
  logic [7:0] wrData;
  logic [7:0] rdData;
  logic [5:0] baudDiv;
  logic [3:0] pulseWidth;
  logic [4:0] preambleLen;
  logic fastOn, midOn, slowOn, txEnable, rxEnable, crc16Sel, cfgError;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  phy_cfg_dbuf dut_i (
    .clk(clk), .rst(rst), .wrEn(wrEn), .regAddr(regAddr), .wrData(wrData),
    .rdData(rdData), .baudDiv(baudDiv), .pulseWidth(pulseWidth),
    .preambleLen(preambleLen), .fastOn(fastOn), .midOn(midOn),
    .slowOn(slowOn), .txEnable(txEnable), .rxEnable(rxEnable),
    .crc16Sel(crc16Sel), .cfgError(cfgError)
  );

  // Row: {write offset, write data, read offset, expected read, requirement}
  localparam int NVEC = 18;
  localparam logic [39:0] VEC [NVEC] = '{
    {8'h18, 8'hE5, 8'h18, 8'hE5, 8'd2},  // R2 pending low byte
    {8'h19, 8'hB4, 8'h19, 8'hB4, 8'd2},  // R2 pending high byte
    {8'h1F, 8'hFF, 8'h16, 8'h00, 8'd2},  // R2 live word untouched
    {8'h15, 8'h80, 8'h15, 8'h80, 8'd8},  // R8 raise control bit
    {8'h15, 8'h24, 8'h16, 8'hE5, 8'd3},  // R3 commit, fast + tx
    {8'h1F, 8'h00, 8'h17, 8'hB4, 8'd3},  // R3 live high byte
    {8'h18, 8'h11, 8'h15, 8'h24, 8'd8},  // R8 enable stored
    {8'h15, 8'h04, 8'h16, 8'hE5, 8'd4},  // R4 low stays low
    {8'h15, 8'hB8, 8'h16, 8'hE5, 8'd4},  // R4 rising edge
    {8'h15, 8'h38, 8'h15, 8'h78, 8'd6},  // R6 three modes -> error
    {8'h1F, 8'h00, 8'h16, 8'hE5, 8'd6},  // R6 live word kept
    {8'h15, 8'h80, 8'h15, 8'hC0, 8'd7},  // R7 error held
    {8'h15, 8'h10, 8'h15, 8'h10, 8'd7},  // R7 good commit clears
    {8'h1F, 8'h00, 8'h16, 8'h11, 8'd3},  // R3 new live low byte
    {8'h16, 8'h99, 8'h16, 8'h11, 8'd9},  // R9 live low write ignored
    {8'h17, 8'h99, 8'h17, 8'hB4, 8'd9},  // R9 live high write ignored
    {8'h1E, 8'h55, 8'h1E, 8'h00, 8'd9},  // R9 unmapped reads zero
    {8'h15, 8'h40, 8'h15, 8'h00, 8'd7}   // R7 bit 6 not host writable
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic writeReg(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; regAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic readCheck(input string req, input logic [4:0] a, input logic [7:0] exp);
    regAddr = a;
    #1;
    check(req, {8'h00, rdData}, {8'h00, exp});
  endtask

  task automatic fieldCheck(input string req, input logic [5:0] b, input logic [3:0] w,
                            input logic [4:0] p);
    check({req, " baud"},  {10'h0, baudDiv},    {10'h0, b});
    check({req, " width"}, {12'h0, pulseWidth}, {12'h0, w});
    check({req, " pre"},   {11'h0, preambleLen},{11'h0, p});
  endtask

  task automatic modeCheck(input string req, input logic [6:0] exp);
    check(req, {9'h0, cfgError, fastOn, midOn, slowOn, txEnable, rxEnable, crc16Sel},
          {9'h0, exp});
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic commitWord(input logic [15:0] w);
    writeReg(5'h18, w[7:0]);
    writeReg(5'h19, w[15:8]);
    writeReg(5'h15, 8'h80);
    writeReg(5'h15, 8'h00);
  endtask

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    rst = 1'b1; wrEn = 1'b0; regAddr = '0; wrData = '0;
    doReset();

    // R1: state after reset
    readCheck("R1 enable", 5'h15, 8'h00);
    readCheck("R1 live lo", 5'h16, 8'h00);
    readCheck("R1 pending hi", 5'h19, 8'h00);
    fieldCheck("R1", 6'h0, 4'h0, 5'h0);
    modeCheck("R1 modes", 7'h00);

    for (int i = 0; i < NVEC; i++) begin
      writeReg(VEC[i][36:32], VEC[i][31:24]);
      regAddr = VEC[i][20:16];
      #1;
      checks++;
      if (rdData !== VEC[i][15:8]) begin
        fails++;
        $display("FAIL R%0d vector %0d: actual %h expected %h",
                 VEC[i][7:0], i, rdData, VEC[i][15:8]);
      end
    end

    // R5: live word 0xB411 decoded
    fieldCheck("R5 word B411", 6'h2D, 4'h8, 5'h11);
    // R8: enable register now zero
    modeCheck("R8 modes cleared", 7'h00);

    // R1: reset after activity
    writeReg(5'h15, 8'hBF);
    doReset();
    readCheck("R1 enable again", 5'h15, 8'h00);
    readCheck("R1 live hi again", 5'h17, 8'h00);
    readCheck("R1 pending lo again", 5'h18, 8'h00);
    fieldCheck("R1 again", 6'h0, 4'h0, 5'h0);

    // R5: split pulse-width field only
    commitWord(16'h04E0);
    fieldCheck("R5 width only", 6'h01, 4'hF, 5'h00);
    // R5: preamble field only
    commitWord(16'h001F);
    fieldCheck("R5 preamble only", 6'h00, 4'h0, 5'h1F);
    // R5: baud field full scale
    commitWord(16'hFC00);
    fieldCheck("R5 baud only", 6'h3F, 4'h8, 5'h00);

    // R8: each enable bit maps to its output
    writeReg(5'h15, 8'h28);
    modeCheck("R8 fast+slow", 7'b0101000);
    writeReg(5'h15, 8'h07);
    modeCheck("R8 tx+rx+crc", 7'b0000111);
    writeReg(5'h15, 8'h10);
    modeCheck("R8 mid", 7'b0010000);

    // R6: two modes on commit rejected, outputs keep 0xFC00
    writeReg(5'h18, 8'h00);
    writeReg(5'h19, 8'h00);
    writeReg(5'h15, 8'h80);
    writeReg(5'h15, 8'h30);
    modeCheck("R6 error flag", 7'b1110000);
    fieldCheck("R6 fields kept", 6'h3F, 4'h8, 5'h00);

    finishRun();
  end

endmodule